// File: doc/BRIEF.md
# Packed Halfword Multiplier Unit

This unit multiplies one 16-bit halfword from each of two packed 32-bit operand words and returns a 32-bit product. For each operand, a select bit picks either the low or the high halfword. A second bit per operand chooses whether that halfword is read as a two's-complement or an unsigned number. The two operands are configured independently, so signed-by-signed, unsigned-by-unsigned and both mixed forms are all available in every cycle.

The unit is a single-cycle datapath element with one output register. A request is presented by raising the valid strobe together with the operands and control bits. The product and an output valid appear on the next clock edge. When the strobe is low, the product register keeps its last value. Each selected halfword is widened to 17 bits, by sign extension when that operand is signed and by zero extension otherwise. A single signed 17x17 multiply then covers all four signedness combinations. The low 32 bits of that multiply hold the exact result in every case.

Top module: `hmul_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted request, out_valid is 0 and product is 0.
- R2: out_valid equals the value in_valid had at the preceding rising clock edge.
- R3: When a_high is 1 the multiplier uses op_a[31:16], and when it is 0 it uses op_a[15:0]. b_high selects the halfword of op_b in the same way.
- R4: When a_signed and b_signed are both 0, product is the unsigned product of the two selected halfwords. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R5: When a_signed and b_signed are both 1, product is the two's-complement product of the two selected halfwords. When both halfwords are nonzero, product bit 31 equals the XOR of their bit 15.
- R6: When exactly one operand is signed, only that operand's halfword is sign-extended, and the other is zero-extended. For example, a signed 0xFFFF times an unsigned 0xFFFF gives 0xFFFF0001.
- R7: A signed 0x8000 times a signed 0x8000 gives exactly 0x40000000.
- R8: While in_valid is 0, product keeps its value and changes to any other input have no effect on it.
- R9: The halfword that is not selected in each operand has no effect on product.
- R10: The product of a request accepted at a clock edge is visible on product right after that edge, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First packed operand word |
| op_b | input | 32 | Second packed operand word |
| a_high | input | 1 | 1 selects op_a[31:16], 0 selects op_a[15:0] |
| b_high | input | 1 | 1 selects op_b[31:16], 0 selects op_b[15:0] |
| a_signed | input | 1 | 1 treats the selected halfword of op_a as two's complement |
| b_signed | input | 1 | 1 treats the selected halfword of op_b as two's complement |
| out_valid | output | 1 | Registered copy of in_valid |
| product | output | 32 | Registered 32-bit product |

## Verification
Each request is checked on product one cycle after it is accepted. A wrong halfword select, a wrong extension or a truncated product therefore shows as a wrong value in the very next cycle. Faults that only affect the sign (a bad extension) are most visible with negative halfwords and mixed signedness. The bench drives these cases directly, and they also appear often in the random traffic. A register that loads without the strobe shows as a changed product during an idle cycle. The bench forces such cycles and changes all operand inputs during them.

// File: rtl/hmul_pkg.sv
package hmul_pkg;

  // Operand lane indices used to index packed per-operand arrays.
  typedef enum logic [0:0] {
    LANE_A = 1'b0,
    LANE_B = 1'b1
  } hmul_lane_e;

  // Per-operand interpretation controls.
  typedef struct packed {
    logic take_high;
    logic is_signed;
  } hmul_ctl_t;

endpackage

// File: rtl/hmul_operand.sv
module hmul_operand #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int EXT_W  = HALF_W + 1
) (
  input  logic [WORD_W-1:0] word,
  input  hmul_pkg::hmul_ctl_t ctl,
  output logic [HALF_W-1:0] half,
  output logic [EXT_W-1:0]  wide
);

  // Pick the low or high halfword of a packed word.
  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                 input logic hi);
    return hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  // Widen by one bit: copy the top bit only when the value is signed.
  function automatic logic [EXT_W-1:0] widen(input logic [HALF_W-1:0] h,
                                             input logic sgn);
    return {sgn & h[HALF_W-1], h};
  endfunction

  always_comb begin
    half = pick_half(word, ctl.take_high);
    wide = widen(half, ctl.is_signed);
  end

endmodule

// File: rtl/hmul_mult.sv
module hmul_mult #(
  parameter int HALF_W = 16,
  localparam int EXT_W  = HALF_W + 1,
  localparam int FULL_W = 2 * EXT_W,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [EXT_W-1:0]  wide_a,
  input  logic [EXT_W-1:0]  wide_b,
  output logic [PROD_W-1:0] prod
);

  // A signed multiply of the widened operands covers all four signedness
  // combinations; the exact result always fits in the low PROD_W bits.
  function automatic logic [PROD_W-1:0] mul_wide(input logic [EXT_W-1:0] x,
                                                 input logic [EXT_W-1:0] y);
    logic signed [FULL_W-1:0] full;
    full = FULL_W'($signed(x)) * FULL_W'($signed(y));
    return full[PROD_W-1:0];
  endfunction

  assign prod = mul_wide(wide_a, wide_b);

endmodule

// File: rtl/hmul_unit.sv
module hmul_unit #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int EXT_W  = HALF_W + 1,
  localparam int PROD_W = 2 * HALF_W,
  localparam int NLANE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              a_high,
  input  logic              b_high,
  input  logic              a_signed,
  input  logic              b_signed,
  output logic              out_valid,
  output logic [PROD_W-1:0] product
);
  import hmul_pkg::*;

  logic [NLANE-1:0][WORD_W-1:0] lane_word;
  hmul_ctl_t [NLANE-1:0]        lane_ctl;
  logic [NLANE-1:0][HALF_W-1:0] lane_half;
  logic [NLANE-1:0][EXT_W-1:0]  lane_wide;
  logic [PROD_W-1:0]            prod_next;
  logic                         load_en;

  assign lane_word[LANE_A] = op_a;
  assign lane_word[LANE_B] = op_b;
  assign lane_ctl[LANE_A]  = '{take_high: a_high, is_signed: a_signed};
  assign lane_ctl[LANE_B]  = '{take_high: b_high, is_signed: b_signed};

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      hmul_operand #(.HALF_W(HALF_W)) u_opnd (
        .word (lane_word[i]),
        .ctl  (lane_ctl[i]),
        .half (lane_half[i]),
        .wide (lane_wide[i])
      );
    end
  endgenerate

  hmul_mult #(.HALF_W(HALF_W)) u_mult (
    .wide_a (lane_wide[LANE_A]),
    .wide_b (lane_wide[LANE_B]),
    .prod   (prod_next)
  );

  assign load_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) product <= prod_next;
    end
  end

  // Named events for the checks below.
  wire sel_a_zero = (lane_half[LANE_A] == '0);
  wire sel_b_zero = (lane_half[LANE_B] == '0);
  wire both_min   = (lane_half[LANE_A] == {1'b1, {(HALF_W-1){1'b0}}}) &&
                    (lane_half[LANE_B] == {1'b1, {(HALF_W-1){1'b0}}});
  wire sgn_sgn    = a_signed && b_signed;
  wire uns_uns    = !a_signed && !b_signed;
  wire sgn_uns    = a_signed && !b_signed;

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid) || $past(!rst_n));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  assert_sign_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sgn_sgn && !sel_a_zero && !sel_b_zero) |=>
      product[PROD_W-1] == $past(lane_half[LANE_A][HALF_W-1] ^ lane_half[LANE_B][HALF_W-1]));

  assert_sign_mixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sgn_uns && !sel_a_zero && !sel_b_zero) |=>
      product[PROD_W-1] == $past(lane_half[LANE_A][HALF_W-1]));

  assert_unsigned_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && uns_uns && (sel_a_zero || sel_b_zero)) |=> product == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sgn_sgn && both_min) |=>
      product == {2'b01, {(PROD_W-2){1'b0}}});

endmodule

// File: tb/tb_hmul_unit.sv
module tb_hmul_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        a_high = 1'b0, b_high = 1'b0, a_signed = 1'b0, b_signed = 1'b0;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hmul_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_high(a_high), .b_high(b_high), .a_signed(a_signed), .b_signed(b_signed),
    .out_valid(out_valid), .product(product)
  );

  // Reference: pick halfword, interpret, multiply in 64-bit arithmetic.
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic ah, input logic bh,
                                          input logic as, input logic bs);
    logic [15:0] ha, hb;
    longint x, y, p;
    ha = ah ? a[31:16] : a[15:0];
    hb = bh ? b[31:16] : b[15:0];
    x = as ? longint'($signed(ha)) : longint'(ha);
    y = bs ? longint'($signed(hb)) : longint'(hb);
    p = x * y;
    return p[31:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge, sample after the next rising edge.
  task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic ah, input logic bh, input logic as, input logic bs);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    a_high = ah; b_high = bh; a_signed = as; b_signed = bs;
    @(negedge clk);
    chk({tag, " R10 product"}, product, ref_mul(a, b, ah, bh, as, bs));
    chk({tag, " R2 out_valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset product", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", product, 32'd0);
    chk("R2 idle out_valid", {31'd0, out_valid}, 32'd0);

    // Directed corners.
    run("R4 uu max", 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, 0);
    chk("R4 uu max literal", product, 32'hFFFE_0001);
    run("R5 ss -1*-1", 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 1, 1);
    chk("R5 ss literal", product, 32'h0000_0001);
    run("R6 su", 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 1, 0);
    chk("R6 su literal", product, 32'hFFFF_0001);
    run("R6 us", 32'h0000_FFFF, 32'h0000_8000, 0, 0, 0, 1);
    chk("R6 us literal", product, 32'h8000_8000);
    run("R7 min*min", 32'h8000_0000, 32'h0000_8000, 1, 0, 1, 1);
    chk("R7 literal", product, 32'h4000_0000);
    run("R3 high/high", 32'h0003_0007, 32'h0005_000B, 1, 1, 0, 0);
    chk("R3 high literal", product, 32'h0000_000F);
    run("R3 low/high", 32'h0003_0007, 32'h0005_000B, 0, 1, 0, 0);
    chk("R3 mixed literal", product, 32'h0000_0023);

    // R9: unselected halfword changes do not change product.
    run("R9 base", 32'h1234_FFF0, 32'hABCD_0010, 0, 0, 1, 1);
    held = product;
    run("R9 other half", 32'h9999_FFF0, 32'h0101_0010, 0, 0, 1, 1);
    chk("R9 unselected ignored", product, held);

    // R8: idle cycles hold product while all other inputs change.
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'hDEAD_BEEF; op_b = 32'h7777_1111;
    a_high = 1; b_high = 1; a_signed = 0; b_signed = 1;
    @(negedge clk);
    chk("R8 hold product", product, held);
    chk("R2 out_valid low", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R8 hold second idle", product, held);

    // Random traffic, with occasional idle cycles.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [3:0] ctl;
      ra = $urandom; rb = $urandom; ctl = 4'($urandom);
      if ((i % 7) == 3) begin
        @(negedge clk);
        held = product;
        in_valid = 1'b0; op_a = ra; op_b = rb;
        @(negedge clk);
        chk("R8 random idle", product, held);
      end else begin
        run("R3/R4/R5/R6 random", ra, rb, ctl[0], ctl[1], ctl[2], ctl[3]);
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule